// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Override

This block turns time-base events into two PWM output levels, A and B. Each time-base tick it looks at the counter's zero and period strobes, the counting direction and the counter value compared against two compare registers. Each output has its own action word, which maps every event to drive-low, drive-high, toggle or nothing. Each output then updates its level from the action that wins.

A continuous override can hold either output low or high for as long as it stays in place. Software writes the override into a shadow copy. The shadow moves into the active copy at a moment that software selects: at counter zero, at period, at either of the two, or on the next tick.

A simple write port loads the compare, action, override and reload registers. The block is used behind a time-base counter and ahead of any dead-band or trip logic.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, every register reads as zero and no override is active.
- R2: A write with regWe high loads the register at its address on that clock edge, and the new value is used from the next edge. The addresses are 0x12 compare A, 0x14 compare B, 0x16 action A, 0x18 action B, 0x1A reload control (bits 7:6) and 0x1C override shadow. Writes to any other address change nothing.
- R3: Events are recognised only in a cycle with tbTick high. Outputs and the active override change only at such a cycle's edge.
- R4: Action word fields are bits 1:0 for zero, bits 3:2 for period, bits 5:4 for compare A while counting up, and bits 9:8 for compare B while counting up. Code 00 does nothing, 01 drives low, 10 drives high and 11 toggles.
- R5: A compare event occurs only when cntUp is high and cntVal equals that compare register. A match while counting down has no effect.
- R6: When several events fall on one tick, the acting code is taken in this order: compare B, then compare A, then period, then zero. The first event in that order that occurs and carries a non-zero code is the one that acts.
- R7: Override shadow bits 1:0 belong to output A and bits 3:2 to output B. In the active override, 01 holds the output low and 10 holds it high, and either one overrides every event action. Codes 00 and 11 leave the events in control.
- R8: On a tick, the shadow is copied into the active override when the reload condition holds: reload code 00 at the zero strobe, 01 at the period strobe, 10 at either strobe, 11 on every tick. A copy takes effect on the output at the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tbTick | input | 1 | Time-base tick enable |
| cntZero | input | 1 | Counter-at-zero strobe |
| cntPrd | input | 1 | Counter-at-period strobe |
| cntUp | input | 1 | High while the counter counts up |
| cntVal | input | 16 | Counter value |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register write address |
| regWdata | input | 16 | Register write data |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |

## Verification
A tick that is sampled at a clock edge changes the output levels and the active override at that same edge. A register write becomes visible only in decisions made from the following edge onward. The bench drives each cycle's inputs after a falling edge and updates its own model with the rule above. It then compares both outputs 2 ns after the rising edge, so every result is read exactly one register stage after its stimulus.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int AQ_ADDR_W = 5;

  localparam logic [AQ_ADDR_W-1:0] OFS_CMP_A   = 5'h12;
  localparam logic [AQ_ADDR_W-1:0] OFS_CMP_B   = 5'h14;
  localparam logic [AQ_ADDR_W-1:0] OFS_ACT_A   = 5'h16;
  localparam logic [AQ_ADDR_W-1:0] OFS_ACT_B   = 5'h18;
  localparam logic [AQ_ADDR_W-1:0] OFS_FRC_CTL = 5'h1A;
  localparam logic [AQ_ADDR_W-1:0] OFS_FRC_SET = 5'h1C;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } actCode_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PRD    = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } rldMode_e;

  // decoded action fields, only the bits that carry meaning
  typedef struct packed {
    logic [1:0] cmpB;
    logic [1:0] cmpA;
    logic [1:0] prd;
    logic [1:0] zero;
  } actSet_t;

  typedef struct packed {
    logic drvLo;
    logic drvHi;
    logic tgl;
  } pinStb_t;

  typedef struct packed {
    pinStb_t [1:0] pin;
    logic          loadForce;
  } ctrlStb_t;
endpackage

// File: rtl/pwm_aq_ctrl.sv
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             tick,
  input  logic             zeroStb,
  input  logic             prdStb,
  input  logic             cntUp,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  actSet_t          actA,
  input  actSet_t          actB,
  input  logic [1:0]       rldMode,
  input  logic [3:0]       forceShd,
  input  logic [3:0]       forceAct,
  output ctrlStb_t         stb
);
  localparam int NUM_PIN = 2;

  logic evZero, evPrd, evCmpA, evCmpB;
  assign evZero = tick && zeroStb;
  assign evPrd  = tick && prdStb;
  assign evCmpA = tick && cntUp && (cntVal == cmpA);
  assign evCmpB = tick && cntUp && (cntVal == cmpB);

  logic loadNow;
  always_comb begin
    unique case (rldMode_e'(rldMode))
      RLD_ZERO:   loadNow = evZero;
      RLD_PRD:    loadNow = evPrd;
      RLD_EITHER: loadNow = evZero || evPrd;
      default:    loadNow = tick;
    endcase
  end

  logic [3:0] forceNext;
  assign forceNext = loadNow ? forceShd : forceAct;

  actSet_t [NUM_PIN-1:0] actV;
  assign actV = {actB, actA};

  pinStb_t [NUM_PIN-1:0] pinV;

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
    logic [1:0] evCode;
    logic [1:0] frc;
    logic       frcOn;
    assign frc   = forceNext[2*g+1:2*g];
    assign frcOn = (frc == ACT_LOW) || (frc == ACT_HIGH);

    // later checks override earlier ones: lowest priority first
    always_comb begin
      evCode = ACT_NONE;
      if (evZero && actV[g].zero != ACT_NONE) evCode = actV[g].zero;
      if (evPrd  && actV[g].prd  != ACT_NONE) evCode = actV[g].prd;
      if (evCmpA && actV[g].cmpA != ACT_NONE) evCode = actV[g].cmpA;
      if (evCmpB && actV[g].cmpB != ACT_NONE) evCode = actV[g].cmpB;
    end

    assign pinV[g].drvLo = tick && (frcOn ? (frc == ACT_LOW)  : (evCode == ACT_LOW));
    assign pinV[g].drvHi = tick && (frcOn ? (frc == ACT_HIGH) : (evCode == ACT_HIGH));
    assign pinV[g].tgl   = tick && !frcOn && (evCode == ACT_TOGGLE);
  end

  assign stb = {pinV, loadNow};
endmodule

// File: rtl/pwm_aq_dpath.sv
module pwm_aq_dpath
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [AQ_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  ctrlStb_t             stb,
  output logic [CNT_W-1:0]     cmpA,
  output logic [CNT_W-1:0]     cmpB,
  output actSet_t              actA,
  output actSet_t              actB,
  output logic [1:0]           rldMode,
  output logic [3:0]           forceShd,
  output logic [3:0]           forceAct,
  output logic [1:0]           pwmOut
);
  localparam int NUM_PIN = 2;

  actSet_t wrAct;
  assign wrAct = '{cmpB: regWdata[9:8], cmpA: regWdata[5:4],
                   prd: regWdata[3:2], zero: regWdata[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpA     <= '0;
      cmpB     <= '0;
      actA     <= '0;
      actB     <= '0;
      rldMode  <= '0;
      forceShd <= '0;
    end else if (regWe) begin
      unique case (regAddr)
        OFS_CMP_A:   cmpA     <= regWdata[CNT_W-1:0];
        OFS_CMP_B:   cmpB     <= regWdata[CNT_W-1:0];
        OFS_ACT_A:   actA     <= wrAct;
        OFS_ACT_B:   actB     <= wrAct;
        OFS_FRC_CTL: rldMode  <= regWdata[7:6];
        OFS_FRC_SET: forceShd <= regWdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              forceAct <= '0;
    else if (stb.loadForce) forceAct <= forceShd;
  end

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pwmOut[g] <= 1'b0;
      else if (stb.pin[g].drvLo) pwmOut[g] <= 1'b0;
      else if (stb.pin[g].drvHi) pwmOut[g] <= 1'b1;
      else if (stb.pin[g].tgl)   pwmOut[g] <= ~pwmOut[g];
    end
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tbTick,
  input  logic                 cntZero,
  input  logic                 cntPrd,
  input  logic                 cntUp,
  input  logic [CNT_W-1:0]     cntVal,
  input  logic                 regWe,
  input  logic [AQ_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic                 pwmA,
  output logic                 pwmB
);
  logic [CNT_W-1:0] cmpA, cmpB;
  actSet_t          actA, actB;
  logic [1:0]       rldMode;
  logic [3:0]       forceShd, forceAct;
  logic [1:0]       pwmOut;
  ctrlStb_t         stb;

  pwm_aq_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .tick(tbTick), .zeroStb(cntZero), .prdStb(cntPrd), .cntUp(cntUp),
    .cntVal(cntVal), .cmpA(cmpA), .cmpB(cmpB), .actA(actA), .actB(actB),
    .rldMode(rldMode), .forceShd(forceShd), .forceAct(forceAct), .stb(stb)
  );

  pwm_aq_dpath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stb(stb), .cmpA(cmpA), .cmpB(cmpB),
    .actA(actA), .actB(actB), .rldMode(rldMode), .forceShd(forceShd),
    .forceAct(forceAct), .pwmOut(pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       pwmA,
  input logic       pwmB,
  input logic [1:0] rldMode,
  input logic [3:0] forceShd,
  input logic [3:0] forceAct
);
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(pwmA) && $stable(pwmB)));

  p_force_lo_a_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !(forceAct[1:0] == 2'b01 && pwmA));

  p_force_hi_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !(forceAct[3:2] == 2'b10 && !pwmB));

  p_force_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(forceAct));

  p_now_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && rldMode == 2'b11) |=> (forceAct == $past(forceShd)));
endmodule

bind pwm_action_qual pwm_aq_chk chk_i (
  .clk(clk), .rstN(rstN), .tick(tbTick), .pwmA(pwmA), .pwmB(pwmB),
  .rldMode(rldMode), .forceShd(forceShd), .forceAct(forceAct)
);

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tbTick = 1'b0, cntZero = 1'b0, cntPrd = 1'b0, cntUp = 1'b1;
  logic [15:0] cntVal = '0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        pwmA, pwmB;

  always #5 clk = ~clk;

  pwm_action_qual dut_i (.*);

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] mCmpA = 0, mCmpB = 0, mActA = 0, mActB = 0;
  logic [1:0]  mRld = 0;
  logic [3:0]  mShd = 0, mAct = 0;
  logic        mA = 0, mB = 0;
  int          cnt = 0, per = 7;

  function automatic logic [1:0] pickCode(logic [15:0] w, bit z, bit p, bit ca, bit cb);
    if (cb && w[9:8] != 2'b00) return w[9:8];
    if (ca && w[5:4] != 2'b00) return w[5:4];
    if (p  && w[3:2] != 2'b00) return w[3:2];
    if (z) return w[1:0];
    return 2'b00;
  endfunction

  function automatic logic nextLvl(logic cur, logic [1:0] frc, logic [1:0] code);
    if (frc == 2'b01) return 1'b0;
    if (frc == 2'b10) return 1'b1;
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit tk, bit z, bit p, bit up, logic [15:0] cv,
                      bit we, logic [4:0] ad, logic [15:0] wd, string tag);
    bit ca, cb, ld;
    logic [3:0] fN;
    tbTick = tk; cntZero = z; cntPrd = p; cntUp = up; cntVal = cv;
    regWe = we; regAddr = ad; regWdata = wd;
    ca = tk && up && (cv == mCmpA);
    cb = tk && up && (cv == mCmpB);
    case (mRld)
      2'b00:   ld = tk && z;
      2'b01:   ld = tk && p;
      2'b10:   ld = tk && (z || p);
      default: ld = tk;
    endcase
    fN = ld ? mShd : mAct;
    @(posedge clk);
    #2;
    if (tk) begin
      mA = nextLvl(mA, fN[1:0], pickCode(mActA, z, p, ca, cb));
      mB = nextLvl(mB, fN[3:2], pickCode(mActB, z, p, ca, cb));
      mAct = fN;
    end
    if (we) begin
      case (ad)
        5'h12: mCmpA = wd;
        5'h14: mCmpB = wd;
        5'h16: mActA = wd;
        5'h18: mActB = wd;
        5'h1A: mRld  = wd[7:6];
        5'h1C: mShd  = wd[3:0];
        default: ;
      endcase
    end
    chk(tag, pwmA, mA, "pwmA");
    chk(tag, pwmB, mB, "pwmB");
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] ad, logic [15:0] wd, string tag);
    step(1'b0, 1'b0, 1'b0, 1'b1, 16'(cnt), 1'b1, ad, wd, tag);
  endtask

  task automatic run(int n, int tickPct, int upPct, int wrPct, string tag);
    for (int i = 0; i < n; i++) begin
      bit tk, we;
      logic [4:0] ad;
      logic [15:0] wd;
      tk = ($urandom % 100) < tickPct;
      we = ($urandom % 100) < wrPct;
      case ($urandom % 9)
        0: ad = 5'h12; 1: ad = 5'h14; 2: ad = 5'h16; 3: ad = 5'h18;
        4: ad = 5'h1A; 5: ad = 5'h1C; 6: ad = 5'h13; 7: ad = 5'h1E;
        default: ad = 5'h00;
      endcase
      wd = 16'($urandom);
      if (ad == 5'h12 || ad == 5'h14) wd = 16'($urandom % (per + 2));
      step(tk, cnt == 0, cnt == per, ($urandom % 100) < upPct,
           16'(cnt), we, ad, wd, tag);
      if (tk) cnt = (cnt == per) ? 0 : cnt + 1;
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1", pwmA, 1'b0, "pwmA in reset");
    chk("R1", pwmB, 1'b0, "pwmB in reset");
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset registers are zero: ticks with events leave outputs low
    step(1'b1, 1'b1, 1'b0, 1'b1, 16'd0, 1'b0, 5'h00, 16'h0, "R1");

    // R4 R5: A high at zero/period, low at compare A up; B toggle on compare B, low at zero
    wr(5'h16, 16'h001A, "R2");
    wr(5'h12, 16'd3, "R2");
    wr(5'h18, 16'h0301, "R2");
    wr(5'h14, 16'd5, "R2");
    cnt = 0; per = 7;
    run(24, 100, 100, 0, "R4");
    // R5: counting down, compare matches ignored
    run(24, 100, 0, 0, "R5");
    // R6: compare A at zero collides with zero event
    wr(5'h12, 16'd0, "R6");
    wr(5'h14, 16'd7, "R6");
    run(24, 100, 100, 0, "R6");
    // R3: no tick, strobes and matches present
    for (int i = 0; i < 6; i++)
      step(1'b0, i[0], i[1], 1'b1, 16'd0, 1'b0, 5'h00, 16'h0, "R3");
    // R2: writes to unused addresses
    wr(5'h13, 16'hFFFF, "R2");
    wr(5'h1E, 16'hFFFF, "R2");
    wr(5'h00, 16'hFFFF, "R2");
    run(16, 100, 100, 0, "R2");
    // R8 R7: immediate reload, force A low and B high
    wr(5'h1A, 16'h00C0, "R8");
    wr(5'h1C, 16'h0009, "R7");
    run(10, 100, 100, 0, "R7");
    // R8: reload at zero only
    wr(5'h1A, 16'h0000, "R8");
    wr(5'h1C, 16'h0006, "R8");
    run(12, 100, 100, 0, "R8");
    // R8: reload at period, code 11 releases
    wr(5'h1A, 16'h0040, "R8");
    wr(5'h1C, 16'h000F, "R8");
    run(12, 100, 100, 0, "R8");
    wr(5'h1A, 16'h0080, "R8");
    wr(5'h1C, 16'h0005, "R8");
    run(12, 100, 100, 0, "R8");
    // random mix
    for (int k = 0; k < 6; k++) begin
      per = 4 + int'($urandom % 9);
      cnt = 0;
      run(500, 75, 90, 10, "R3 R4 R5 R6 R7 R8");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule